// File: doc/BRIEF.md
# Real-Time Clock Alarm Compare and Interrupt Controller

This block produces the single interrupt line of a real-time clock. It keeps eight alarm bytes, one for each time field, and compares them with the live counter values every cycle. It merges the alarm event with six periodic rollover strobes, from hundredths of a second up to days, through a combined enable and flag register. Software reads that register to clear it.

Software reaches the block over a small byte bus with single-cycle read and write strobes. Reads return data combinationally in the same cycle as the strobe. A write-only command byte holds the global interrupt enable. The interrupt output stays asserted until software reads the status register. The counters themselves live outside the block and come in through `live_time` and `roll_stb`.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After a synchronous active-high reset, every alarm byte, the enable bits, the pending flag and the interrupt enable are zero, and `irq` is low.
- R2: Alarm bytes sit at offsets 8 to 15. The fields are hundredths at 8, hour at 9, minute at 10, second at 11, month at 12, day at 13, year at 14 and weekday at 15. Reading an offset returns the whole byte last written there. Field k of `live_time` is bits [8k+7:8k].
- R3: The alarm source fires in the single cycle where the compare of all fields changes from false to true. It does not fire again while the match holds.
- R4: For every field except hour, bit 7 of the alarm byte set removes the field from the compare. Otherwise alarm bits 6:0 must equal live bits 6:0, and bit 7 of the live value is not compared.
- R5: For the hour field, bit 6 of the alarm byte set removes the field from the compare. Otherwise alarm bits 7 and 5:0 must equal the live bits, and live bit 6 is not compared.
- R6: Status offset 16 bits 6:0 are enables: bit 0 alarm, bit 1 hundredth, bit 2 tenth, bit 3 second, bit 4 minute, bit 5 hour, bit 6 day. `roll_stb[i]` is the source for enable bit i+1. An enabled source that fires sets the pending flag. A disabled source has no effect.
- R7: A read of offset 16 returns the pending flag in bit 7 and the enables in bits 6:0. Bit 7 of a write there is ignored.
- R8: A read of offset 16 clears the pending flag. If an enabled source fires in the same cycle, the read shows the old value and the flag is set again afterwards. Enables written in a cycle take effect from the next cycle.
- R9: Bit 4 of a write to offset 17 is the interrupt enable. `irq` equals pending AND enable. Offset 17 reads as zero.
- R10: While the enable stays set, `irq` stays high until a read of offset 16.
- R11: Offsets 0 to 7 and 18 to 31 read as zero, and writes to them change nothing.
- R12: `bus_rdata` is zero in any cycle without `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| live_time | input | 64 | Live counter values, eight bytes, field k at [8k+7:8k] |
| roll_stb | input | 6 | Rollover strobes: hundredth, tenth, second, minute, hour, day |
| irq | output | 1 | Interrupt request |

## Verification
A corrupt alarm byte or ignore decode shows up as a missing or extra `irq` one cycle after the live value arrives. It also shows in the value an offset 8 to 15 read returns in the same cycle. A stuck match history shows up as repeated interrupts while a match holds, or as no interrupt at the next match. A wrong pending or enable state shows at once in bit 7 or bits 6:0 of a status read, and in `irq`. The reference model is compared on every cycle, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/rtcirq_pkg.sv
package rtcirq_pkg;

    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 8;
    localparam int FIDX_W     = $clog2(NUM_FIELDS);
    localparam int ADDR_W     = 5;
    localparam int NUM_ROLL   = 6;
    localparam int NUM_SRC    = NUM_ROLL + 1;

    // Register map; the alarm field order is decoded by the neighbouring counters
    localparam int ALARM_BASE = 8;
    localparam int STAT_OFS   = 16;
    localparam int CMD_OFS    = 17;
    localparam int HOUR_IDX   = 1;
    localparam int IE_BIT     = 4;

    typedef logic [FIELD_W-1:0] field_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_ALARM,
        ACC_STAT,
        ACC_CMD
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e         kind;
        logic [FIDX_W-1:0] idx;
    } acc_dec_t;

    typedef struct packed {
        logic               pend;
        logic [NUM_SRC-1:0] en;
    } stat_view_t;

    // Exclusion bit of an alarm field: hour uses the bit below the top one
    function automatic field_t ignore_mask(input int idx);
        return field_t'(1) << ((idx == HOUR_IDX) ? FIELD_W - 2 : FIELD_W - 1);
    endfunction

    function automatic acc_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        acc_dec_t d;
        int       ai;
        ai     = int'(a);
        d.kind = ACC_NONE;
        d.idx  = '0;
        if (ai >= ALARM_BASE && ai < ALARM_BASE + NUM_FIELDS) begin
            d.kind = ACC_ALARM;
            d.idx  = FIDX_W'(ai - ALARM_BASE);
        end else if (ai == STAT_OFS) begin
            d.kind = ACC_STAT;
        end else if (ai == CMD_OFS) begin
            d.kind = ACC_CMD;
        end
        return d;
    endfunction

endpackage

// File: rtl/rtcirq_alarm_bank.sv
module rtcirq_alarm_bank
    import rtcirq_pkg::*;
#(
    parameter int NF = NUM_FIELDS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [$clog2(NF)-1:0] idx,
    input  field_t                wr_data,
    input  logic [NF*FIELD_W-1:0] live,
    output field_t                rd_data,
    output logic                  alarm_hit
);

    localparam int IW = $clog2(NF);

    field_t          regs [NF];
    logic [NF-1:0]   fld_ok;
    logic            match_q;

    for (genvar k = 0; k < NF; k++) begin : g_field
        localparam field_t IGN = ignore_mask(k);

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[k] <= '0;
            end else if (wr_en && idx == IW'(k)) begin
                regs[k] <= wr_data;
            end
        end

        // Field agrees when excluded, or when every compared bit is equal
        assign fld_ok[k] = ((regs[k] & IGN) != '0) ||
                           (((regs[k] ^ live[k*FIELD_W +: FIELD_W]) & ~IGN) == '0);
    end

    assign rd_data = regs[idx];

    // Match history: the alarm event is the false-to-true transition
    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= 1'b0;
        end else begin
            match_q <= &fld_ok;
        end
    end

    assign alarm_hit = (&fld_ok) & ~match_q;

endmodule

// File: rtl/rtcirq_status.sv
module rtcirq_status
    import rtcirq_pkg::*;
#(
    parameter int NR = NUM_ROLL
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alarm_hit,
    input  logic [NR-1:0] roll_stb,
    input  logic          mask_wr,
    input  logic [NR:0]   mask_wdata,
    input  logic          stat_rd,
    input  logic          ie_wr,
    input  logic          ie_wdata,
    output logic [NR:0]   mask_q,
    output logic          pend_q,
    output logic          irq
);

    logic [NR:0] src;
    logic        fired;
    logic        ie_q;

    assign src   = {roll_stb, alarm_hit};
    assign fired = |(src & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ie_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (mask_wr) begin
                mask_q <= mask_wdata;
            end
            if (ie_wr) begin
                ie_q <= ie_wdata;
            end
            // A read drops the old flag but keeps an event of the same cycle
            pend_q <= stat_rd ? fired : (pend_q | fired);
        end
    end

    assign irq = pend_q & ie_q;

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtcirq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_rd,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [FIELD_W-1:0]            bus_wdata,
    output logic [FIELD_W-1:0]            bus_rdata,
    input  logic [NUM_FIELDS*FIELD_W-1:0] live_time,
    input  logic [NUM_ROLL-1:0]           roll_stb,
    output logic                          irq
);

    acc_dec_t           dec;
    logic               alarm_wr;
    logic               stat_wr;
    logic               stat_rd;
    logic               cmd_wr;
    field_t             alarm_rd;
    logic               alarm_hit;
    logic [NUM_SRC-1:0] mask_q;
    logic               pend_q;
    stat_view_t         sview;

    assign dec      = decode_addr(bus_addr);
    assign alarm_wr = bus_wr && dec.kind == ACC_ALARM;
    assign stat_wr  = bus_wr && dec.kind == ACC_STAT;
    assign stat_rd  = bus_rd && dec.kind == ACC_STAT;
    assign cmd_wr   = bus_wr && dec.kind == ACC_CMD;

    rtcirq_alarm_bank #(
        .NF(NUM_FIELDS)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (alarm_wr),
        .idx      (dec.idx),
        .wr_data  (bus_wdata),
        .live     (live_time),
        .rd_data  (alarm_rd),
        .alarm_hit(alarm_hit)
    );

    rtcirq_status #(
        .NR(NUM_ROLL)
    ) u_stat (
        .clk       (clk),
        .rst       (rst),
        .alarm_hit (alarm_hit),
        .roll_stb  (roll_stb),
        .mask_wr   (stat_wr),
        .mask_wdata(bus_wdata[NUM_SRC-1:0]),
        .stat_rd   (stat_rd),
        .ie_wr     (cmd_wr),
        .ie_wdata  (bus_wdata[IE_BIT]),
        .mask_q    (mask_q),
        .pend_q    (pend_q),
        .irq       (irq)
    );

    assign sview.pend = pend_q;
    assign sview.en   = mask_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (dec.kind)
                ACC_ALARM: bus_rdata = alarm_rd;
                ACC_STAT:  bus_rdata = sview;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rtcirq_chk.sv
module rtcirq_chk
    import rtcirq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [FIELD_W-1:0]  bus_rdata,
    input logic [NUM_ROLL-1:0] roll_stb,
    input logic                alarm_hit,
    input logic                irq
);

    logic rd_stat;
    logic wr_cmd;

    assign rd_stat = bus_rd && bus_addr == ADDR_W'(STAT_OFS);
    assign wr_cmd  = bus_wr && bus_addr == ADDR_W'(CMD_OFS);

    AST_ALARM_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        alarm_hit |=> !alarm_hit); // R3

    AST_IRQ_CAUSED: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(roll_stb != '0 || alarm_hit || wr_cmd)); // R6

    AST_PEND_SHOWN: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && irq) |-> bus_rdata[FIELD_W-1]); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && roll_stb == '0 && !alarm_hit) |=> !irq); // R8

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (irq && !rd_stat && !wr_cmd) |=> irq); // R10

    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == '0); // R12

endmodule

bind rtc_alarm_irq rtcirq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .roll_stb (roll_stb),
    .alarm_hit(alarm_hit),
    .irq      (irq)
);

// File: tb/tb_rtc_alarm_irq.sv
module tb_rtc_alarm_irq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [63:0] live = '0;
    logic [5:0]  roll = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state
    logic [7:0] m_al [8];
    logic [6:0] m_mask;
    bit         m_pend, m_ie, m_prev;

    rtc_alarm_irq dut (
        .clk      (clk),
        .rst      (rst),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .live_time(live),
        .roll_stb (roll),
        .irq      (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // R4/R5: excluded field, or compared bits equal
    function automatic bit m_match();
        bit m = 1;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] ig = (k == 1) ? 8'h40 : 8'h80;
            if ((m_al[k] & ig) == 0 && ((m_al[k] ^ live[k*8 +: 8]) & ~ig) != 0) m = 0;
        end
        return m;
    endfunction

    function automatic logic [7:0] m_rdata();
        int a = int'(bus_addr);
        if (!bus_rd) return 8'h00;
        if (a >= 8 && a <= 15) return m_al[a-8];
        if (a == 16) return {m_pend, m_mask};
        return 8'h00;
    endfunction

    task automatic model_step();
        if (rst) begin
            for (int k = 0; k < 8; k++) m_al[k] = '0;
            m_mask = '0; m_pend = 0; m_ie = 0; m_prev = 0;
        end else begin
            bit mt  = m_match();
            bit hit = mt && !m_prev;
            bit ev  = (({roll, hit} & m_mask) != 0);
            int a   = int'(bus_addr);
            m_pend = (bus_rd && a == 16) ? ev : (m_pend || ev);
            m_prev = mt;
            if (bus_wr) begin
                if (a >= 8 && a <= 15) m_al[a-8] = bus_wdata;
                else if (a == 16) m_mask = bus_wdata[6:0];
                else if (a == 17) m_ie = bus_wdata[4];
            end
        end
    endtask

    task automatic tick();
        #1;
        if (!rst) begin
            check("R2/R7/R11/R12 rdata vs model", bus_rdata, m_rdata());
            check("R9/R10 irq vs model", {7'b0, irq}, {7'b0, m_pend && m_ie});
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        bus_wr = 1; bus_addr = 5'(a); bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        bus_rd = 1; bus_addr = 5'(a);
        #1 v = bus_rdata;
        tick();
        bus_rd = 0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        @(negedge clk);
        repeat (3) tick();
        rst = 0;

        // R1 reset state
        rd(16, v); check("R1 status after reset", v, 8'h00);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);

        // R2 alarm bytes read back
        wr(8, 8'h05); wr(9, 8'h40);
        for (int k = 10; k < 16; k++) wr(k, 8'h80 | 8'(k));
        rd(8, v);  check("R2 hundredths byte", v, 8'h05);
        rd(9, v);  check("R2 hour byte", v, 8'h40);
        rd(13, v); check("R2 day byte", v, 8'h8D);
        rd(15, v); check("R2 weekday byte", v, 8'h8F);

        // R3 alarm fires once
        wr(17, 8'h10); wr(16, 8'h01);
        live[7:0] = 8'h04; tick();
        check("R3 no match yet", {7'b0, irq}, 8'h00);
        live[7:0] = 8'h05; tick();
        check("R3 irq on match", {7'b0, irq}, 8'h01);
        repeat (3) tick();
        check("R10 irq held", {7'b0, irq}, 8'h01);
        rd(16, v); check("R7 status pending+enable", v, 8'h81);
        check("R8 irq cleared by read", {7'b0, irq}, 8'h00);
        repeat (4) tick();
        check("R3 no refire while match holds", {7'b0, irq}, 8'h00);

        // R4 non-hour exclusion and bit 7 not compared
        wr(8, 8'h85);
        wr(10, 8'h07); tick();
        live[23:16] = 8'h87; tick();
        check("R4 minute match ignoring live bit7", {7'b0, irq}, 8'h01);
        rd(16, v);

        // R5 hour field
        wr(9, 8'h12); tick();
        check("R5 hour mismatch", {7'b0, irq}, 8'h00);
        live[15:8] = 8'h52; tick();
        check("R5 hour match ignoring live bit6", {7'b0, irq}, 8'h01);
        rd(16, v);
        live[15:8] = 8'hD2; tick(); tick();
        check("R5 hour bit7 compared", {7'b0, irq}, 8'h00);
        wr(9, 8'h40); tick();
        check("R5 hour excluded by bit6", {7'b0, irq}, 8'h01);
        rd(16, v);

        // R6 periodic sources
        wr(16, 8'h08);
        roll = 6'b000001; tick(); roll = '0; tick();
        check("R6 disabled source ignored", {7'b0, irq}, 8'h00);
        roll = 6'b000100; tick(); roll = '0;
        check("R6 second source", {7'b0, irq}, 8'h01);

        // R8 event in the read cycle is kept
        bus_rd = 1; bus_addr = 5'd16; roll = 6'b000100;
        #1 v = bus_rdata;
        tick();
        bus_rd = 0; roll = '0;
        check("R8 read shows old state", v, 8'h88);
        check("R8 same-cycle event kept", {7'b0, irq}, 8'h01);

        // R9 global enable
        wr(17, 8'h00);
        check("R9 irq gated off", {7'b0, irq}, 8'h00);
        wr(17, 8'h10);
        check("R9 irq gated on", {7'b0, irq}, 8'h01);
        rd(17, v); check("R9 command reads zero", v, 8'h00);
        rd(16, v);

        // R7 write bit7 ignored
        wr(16, 8'hFF);
        rd(16, v); check("R7 bit7 write ignored", v, 8'h7F);

        // R11 unmapped offsets
        wr(3, 8'hFF); rd(3, v); check("R11 offset 3 reads zero", v, 8'h00);
        wr(20, 8'hFF); rd(20, v); check("R11 offset 20 reads zero", v, 8'h00);
        #1 check("R12 idle rdata", bus_rdata, 8'h00);

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            for (int k = 0; k < 8; k++) begin
                if ($urandom_range(0, 3) == 0)
                    live[k*8 +: 8] = 8'($urandom_range(0, 1)) | (($urandom_range(0, 3) == 0) ? 8'hC0 : 8'h00);
            end
            roll = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'b0;
            bus_rd = ($urandom_range(0, 3) == 0);
            bus_wr = ($urandom_range(0, 5) == 0);
            case ($urandom_range(0, 3))
                0: bus_addr = 5'd16;
                1: bus_addr = 5'd17;
                2: bus_addr = 5'(8 + $urandom_range(0, 7));
                default: bus_addr = 5'($urandom);
            endcase
            case ($urandom_range(0, 3))
                0: bus_wdata = 8'h00;
                1: bus_wdata = 8'h01;
                2: bus_wdata = 8'h80;
                default: bus_wdata = 8'($urandom);
            endcase
            tick();
        end
        bus_rd = 0; bus_wr = 0; roll = '0;
        tick();

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule